// File: doc/BRIEF.md
# Word-Serial Circular Vectoring Arctangent Unit

This block takes a two's-complement vector (X, Y) and returns its polar angle and its scaled length. It works word-serially: one shift-and-add micro-rotation per clock, fourteen in all. Each micro-rotation turns the vector towards the positive X axis. The sign of the current Y value picks the direction, so Y is driven towards zero. A Z register starts from a base angle and adds or subtracts one stored elementary angle per step. When the sequence ends, Z holds the angle of the input vector and X holds its length times the fixed CORDIC gain (about 1.6468).

A vector with a negative X is first turned by a quarter turn into the right half-plane, and the base angle becomes plus or minus a quarter turn. This lets the result cover the whole circle, from -pi to +pi.

A client pulses `start` with the operands on `x_in`/`y_in` and waits for the one-cycle `done_o` pulse. It then reads `angle_o` and `mag_o`, which hold their values until the next accepted start.

Top module: `cordic_vec_atan`

## Requirements
- R1: With defaults, `angle_o` is a signed 16-bit value in radians with 13 fractional bits (radians x 8192). At completion it equals, bit for bit, the following sequence: Z starts at the base angle; for i = 0..13, if Y >= 0 then X += Y>>>i, Y -= X>>>i, Z += A[i], else X -= Y>>>i, Y += X>>>i, Z -= A[i]. Here A[i] = round(atan(2^-i) x 8192), and >>> is an arithmetic (flooring) shift.
- R2: The direction of every micro-rotation comes from the sign of the current Y register. Z grows on a step taken with Y >= 0 and shrinks on a step taken with Y < 0.
- R3: `mag_o` (signed, 18 bits, same scale as the inputs) equals the final X of the R1 sequence. This is the gain times sqrt(X0^2 + Y0^2).
- R4: For X0 >= 0 the sequence starts from (X0, Y0) with a base angle of 0. For X0 < 0 and Y0 >= 0 it starts from (Y0, -X0) with a base angle of +12868 (round(pi/2 x 8192)). For X0 < 0 and Y0 < 0 it starts from (-Y0, X0) with a base angle of -12868.
- R5: The input X0 = 0, Y0 = 0 yields `angle_o` = 0 and `mag_o` = 0.
- R6: `done_o` is high for exactly one cycle. It rises with the 15th rising edge counted from the edge that samples `start` (one load edge followed by 14 iteration edges).
- R7: A `start` pulse that arrives while a computation is in progress is ignored. Neither the running result nor its completion time changes.
- R8: After reset, `done_o`, `angle_o` and `mag_o` are all 0.
- R9: Once done, `angle_o` and `mag_o` stay unchanged until the next accepted `start`, whatever happens on `x_in`/`y_in`.
- R10: For vectors of length at least 1000, `angle_o` is within 24 LSB (0.003 rad) of atan2(Y0, X0). `mag_o` is within 0.5 % + 4 of 1.64676 x length.
- R11: Iterations run strictly one per clock, with the iteration index advancing by exactly one from 0 to 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation; sampled only when idle |
| x_in | input | 16 | Signed X operand |
| y_in | input | 16 | Signed Y operand |
| angle_o | output | 16 | Signed angle, radians x 8192 |
| mag_o | output | 18 | Signed scaled magnitude |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: 16-bit operands, 14 iterations and 13 fractional angle bits. At this size a bit-exact integer model of the micro-rotation sequence can be checked on every vector. The vectors are a full circle sampled every degree, a dense 16 x 16 grid of small operands around the origin, and the extreme corners and axes of the input range. Together these exercise all three pre-rotation branches, both step directions at every shift amount, the zero vector, and the negative-full-scale values whose negation needs the extra guard bits. The large-radius vectors also receive a floating-point atan2 and length comparison, which is independent of the fixed-point model.

// File: rtl/cordic_vec_pkg.sv
package cordic_vec_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} ctrl_state_e;

  // Elementary angle atan(2^-idx) scaled by 2^30.
  function automatic longint atan_q30(input int idx);
    case (idx)
      0:  return 64'sd843314857;
      1:  return 64'sd497837829;
      2:  return 64'sd263043837;
      3:  return 64'sd133525159;
      4:  return 64'sd67021687;
      5:  return 64'sd33543516;
      6:  return 64'sd16775851;
      7:  return 64'sd8388437;
      8:  return 64'sd4194283;
      9:  return 64'sd2097149;
      10: return 64'sd1048576;
      11: return 64'sd524288;
      12: return 64'sd262144;
      13: return 64'sd131072;
      default: return (idx <= 30) ? (64'sd1 <<< (30 - idx)) : 64'sd0;
    endcase
  endfunction

  // Rescale a 2^30 constant to af fractional bits with rounding.
  function automatic int rescale_q30(input longint q30, input int af);
    longint r;
    r = (q30 + (64'sd1 <<< (29 - af))) >>> (30 - af);
    return int'(r);
  endfunction

  function automatic int angle_const(input int idx, input int af);
    return rescale_q30(atan_q30(idx), af);
  endfunction

  // Quarter turn, pi/2 scaled by 2^30.
  function automatic int half_pi_const(input int af);
    return rescale_q30(64'sd1686629713, af);
  endfunction

endpackage

// File: rtl/cordic_vec_ctrl.sv
module cordic_vec_ctrl #(
  parameter int ITER = 14,
  localparam int CW  = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          load_en,
  output logic          step_en,
  output logic          busy,
  output logic [CW-1:0] iter_idx,
  output logic          done_q
);
  import cordic_vec_pkg::*;

  localparam logic [CW-1:0] LAST_IDX = CW'(ITER - 1);

  ctrl_state_e state_q;
  logic        last_step;

  assign busy      = (state_q == ST_RUN);
  assign load_en   = start && !busy;
  assign step_en   = busy;
  assign last_step = step_en && (iter_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      iter_idx <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_step;
      if (load_en) begin
        state_q  <= ST_RUN;
        iter_idx <= '0;
      end else if (last_step) begin
        state_q  <= ST_IDLE;
        iter_idx <= '0;
      end else if (step_en) begin
        iter_idx <= iter_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cordic_vec_prerot.sv
module cordic_vec_prerot #(
  parameter int DW = 16,
  parameter int IW = DW + 2,
  parameter int AW = DW,
  parameter int AF = 13
) (
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [AW-1:0] z_o,
  output logic                 is_zero
);
  localparam int HP_I = cordic_vec_pkg::half_pi_const(AF);
  localparam logic signed [AW-1:0] HP_POS = AW'(HP_I);
  localparam logic signed [AW-1:0] HP_NEG = AW'(-HP_I);

  logic signed [IW-1:0] xe, ye;

  assign xe      = IW'(x_in);
  assign ye      = IW'(y_in);
  assign is_zero = (x_in == '0) && (y_in == '0);

  always_comb begin
    if (x_in[DW-1] && !y_in[DW-1]) begin
      x_o = ye;
      y_o = -xe;
      z_o = HP_POS;
    end else if (x_in[DW-1]) begin
      x_o = -ye;
      y_o = xe;
      z_o = HP_NEG;
    end else begin
      x_o = xe;
      y_o = ye;
      z_o = '0;
    end
  end
endmodule

// File: rtl/cordic_vec_datapath.sv
module cordic_vec_datapath #(
  parameter int IW   = 18,
  parameter int AW   = 16,
  parameter int AF   = 13,
  parameter int ITER = 14,
  localparam int CW  = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic                 step_en,
  input  logic [CW-1:0]        iter_idx,
  input  logic signed [IW-1:0] x_init,
  input  logic signed [IW-1:0] y_init,
  input  logic signed [AW-1:0] z_init,
  input  logic                 zero_init,
  output logic signed [IW-1:0] x_q,
  output logic signed [AW-1:0] z_q,
  output logic                 zero_q,
  output logic                 y_neg
);
  logic signed [IW-1:0] y_q;
  logic signed [AW-1:0] atan_tab [ITER];
  logic signed [IW-1:0] x_nx, y_nx;
  logic signed [AW-1:0] z_nx;

  for (genvar g = 0; g < ITER; g++) begin : g_tab
    assign atan_tab[g] = AW'(cordic_vec_pkg::angle_const(g, AF));
  end

  function automatic logic signed [IW-1:0] shr(
    input logic signed [IW-1:0] v, input logic [CW-1:0] s);
    return v >>> s;
  endfunction

  // One micro-rotation: toward_neg set means Y is negative, so rotate up.
  function automatic logic signed [IW-1:0] next_x(
    input logic signed [IW-1:0] x, input logic signed [IW-1:0] y,
    input logic [CW-1:0] s, input logic toward_neg);
    return toward_neg ? x - shr(y, s) : x + shr(y, s);
  endfunction

  function automatic logic signed [IW-1:0] next_y(
    input logic signed [IW-1:0] x, input logic signed [IW-1:0] y,
    input logic [CW-1:0] s, input logic toward_neg);
    return toward_neg ? y + shr(x, s) : y - shr(x, s);
  endfunction

  function automatic logic signed [AW-1:0] next_z(
    input logic signed [AW-1:0] z, input logic signed [AW-1:0] a,
    input logic toward_neg);
    return toward_neg ? z - a : z + a;
  endfunction

  assign y_neg = y_q[IW-1];
  assign x_nx  = next_x(x_q, y_q, iter_idx, y_neg);
  assign y_nx  = next_y(x_q, y_q, iter_idx, y_neg);
  assign z_nx  = next_z(z_q, atan_tab[iter_idx], y_neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      zero_q <= 1'b1;
    end else if (load_en) begin
      x_q    <= x_init;
      y_q    <= y_init;
      z_q    <= z_init;
      zero_q <= zero_init;
    end else if (step_en) begin
      x_q <= x_nx;
      y_q <= y_nx;
      z_q <= z_nx;
    end
  end
endmodule

// File: rtl/cordic_vec_atan.sv
module cordic_vec_atan #(
  parameter int DW   = 16,
  parameter int ITER = 14,
  parameter int AF   = 13,
  localparam int IW  = DW + 2,
  localparam int AW  = DW,
  localparam int CW  = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  output logic signed [AW-1:0] angle_o,
  output logic signed [IW-1:0] mag_o,
  output logic                 done_o
);
  logic                 load_en, step_en, busy, y_neg, zero_q, pre_zero;
  logic [CW-1:0]        iter_idx;
  logic signed [IW-1:0] pre_x, pre_y, x_q;
  logic signed [AW-1:0] pre_z, z_q;

  cordic_vec_ctrl #(.ITER(ITER)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load_en(load_en), .step_en(step_en), .busy(busy),
    .iter_idx(iter_idx), .done_q(done_o)
  );

  cordic_vec_prerot #(.DW(DW), .IW(IW), .AW(AW), .AF(AF)) u_prerot (
    .x_in(x_in), .y_in(y_in),
    .x_o(pre_x), .y_o(pre_y), .z_o(pre_z), .is_zero(pre_zero)
  );

  cordic_vec_datapath #(.IW(IW), .AW(AW), .AF(AF), .ITER(ITER)) u_dp (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .step_en(step_en),
    .iter_idx(iter_idx), .x_init(pre_x), .y_init(pre_y), .z_init(pre_z),
    .zero_init(pre_zero), .x_q(x_q), .z_q(z_q), .zero_q(zero_q),
    .y_neg(y_neg)
  );

  assign angle_o = zero_q ? '0 : z_q;
  assign mag_o   = zero_q ? '0 : x_q;
endmodule

// File: rtl/cordic_vec_atan_chk.sv
module cordic_vec_atan_chk #(
  parameter int DW   = 16,
  parameter int ITER = 14,
  parameter int AF   = 13,
  localparam int IW  = DW + 2,
  localparam int AW  = DW,
  localparam int CW  = (ITER > 1) ? $clog2(ITER) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic signed [DW-1:0] x_in,
  input logic signed [DW-1:0] y_in,
  input logic signed [AW-1:0] angle_o,
  input logic signed [IW-1:0] mag_o,
  input logic                 done_o,
  input logic                 load_en,
  input logic                 step_en,
  input logic                 busy,
  input logic [CW-1:0]        iter_idx,
  input logic                 y_neg,
  input logic signed [AW-1:0] z_q
);
  localparam int HP_I = cordic_vec_pkg::half_pi_const(AF);
  localparam logic signed [AW-1:0] HP_POS = AW'(HP_I);
  localparam logic signed [AW-1:0] HP_NEG = AW'(-HP_I);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_z_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !y_neg) |=> (z_q > $past(z_q)));

  assert_z_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && y_neg) |=> (z_q < $past(z_q)));

  assert_iter_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && iter_idx != CW'(ITER - 1)) |=>
      (step_en && iter_idx == CW'($past(iter_idx) + 1'b1)));

  assert_base_upper_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && x_in[DW-1] && !y_in[DW-1]) |=> (z_q == HP_POS));

  assert_base_lower_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && x_in[DW-1] && y_in[DW-1]) |=> (z_q == HP_NEG));

  assert_zero_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && x_in == '0 && y_in == '0) |=> (angle_o == '0 && mag_o == '0));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(angle_o) && $stable(mag_o)));
endmodule

bind cordic_vec_atan cordic_vec_atan_chk #(.DW(DW), .ITER(ITER), .AF(AF)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
  .angle_o(angle_o), .mag_o(mag_o), .done_o(done_o), .load_en(load_en),
  .step_en(step_en), .busy(busy), .iter_idx(iter_idx), .y_neg(y_neg),
  .z_q(z_q)
);

// File: tb/cordic_vec_atan_tb.sv
module cordic_vec_atan_tb;
  localparam int  DW       = 16;
  localparam int  ITER     = 14;
  localparam int  AF       = 13;
  localparam time CLK_HALF = 5ns;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic signed [DW-1:0] x_in = '0, y_in = '0;
  logic signed [DW-1:0] angle_o;
  logic signed [DW+1:0] mag_o;
  logic done_o;

  int checks = 0, fails = 0;
  longint at_tab [ITER];
  longint half_pi;
  real    pi_r;

  always #(CLK_HALF) clk = ~clk;

  cordic_vec_atan #(.DW(DW), .ITER(ITER), .AF(AF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .angle_o(angle_o), .mag_o(mag_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Integer restatement of the R1/R4/R5 sequence.
  function automatic void model(input longint x0, input longint y0,
                                output longint ang, output longint mag);
    longint x, y, z, xn;
    if (x0 == 0 && y0 == 0) begin ang = 0; mag = 0; return; end
    if (x0 < 0 && y0 >= 0)   begin x = y0;  y = -x0; z = half_pi;  end
    else if (x0 < 0)         begin x = -y0; y = x0;  z = -half_pi; end
    else                     begin x = x0;  y = y0;  z = 0;        end
    for (int i = 0; i < ITER; i++) begin
      if (y >= 0) begin xn = x + (y >>> i); y = y - (x >>> i); z = z + at_tab[i]; end
      else        begin xn = x - (y >>> i); y = y + (x >>> i); z = z - at_tab[i]; end
      x = xn;
    end
    ang = z; mag = x;
  endfunction

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done_o && lat < 40) begin @(negedge clk); lat++; end
  endtask

  task automatic run_vec(input int xv, input int yv, input string tag);
    longint ea, em;
    int lat;
    real r, ref_a, err;
    model(xv, yv, ea, em);
    @(negedge clk); x_in = DW'(xv); y_in = DW'(yv); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(lat);
    chk(lat == ITER + 1, "R6", "done latency", lat, ITER + 1);
    chk(longint'(angle_o) == ea, tag, "angle", angle_o, ea);
    chk(longint'(mag_o) == em, "R3", "magnitude", mag_o, em);
    r = $sqrt(real'(xv) * xv + real'(yv) * yv);
    if (r >= 1000.0) begin
      ref_a = $atan2(real'(yv), real'(xv)) * 8192.0;
      err = real'(angle_o) - ref_a;
      if (err < 0) err = -err;
      chk(err <= 24.0, "R10", "angle accuracy", angle_o, longint'(ref_a));
      err = real'(mag_o) - 1.64676 * r;
      if (err < 0) err = -err;
      chk(err <= 0.005 * r + 4.0, "R10", "magnitude accuracy", mag_o,
          longint'(1.64676 * r));
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R6", "done width", done_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    longint ea, em, a0, m0;
    int lat;
    pi_r = $acos(-1.0);
    for (int i = 0; i < ITER; i++)
      at_tab[i] = longint'($rtoi($atan(1.0 / (2.0 ** i)) * 8192.0 + 0.5));
    half_pi = longint'($rtoi(pi_r / 2.0 * 8192.0 + 0.5));

    repeat (3) @(negedge clk);
    // R8: reset values
    chk(done_o == 1'b0, "R8", "done after reset", done_o, 0);
    chk(angle_o == 0, "R8", "angle after reset", angle_o, 0);
    chk(mag_o == 0, "R8", "magnitude after reset", mag_o, 0);
    rst_n = 1'b1;

    // R5 zero vector, R4 axes and corners
    run_vec(0, 0, "R5");
    chk(angle_o == 0 && mag_o == 0, "R5", "zero vector", angle_o, 0);
    run_vec(-16384, 0, "R4");
    chk(angle_o > 25000, "R4", "negative X axis near +pi", angle_o, 25736);
    run_vec(-32768, -32768, "R4");
    run_vec(-32768, 32767, "R4");
    run_vec(32767, -32768, "R1");
    run_vec(32767, 32767, "R1");
    run_vec(0, -32768, "R1");
    run_vec(0, 32767, "R1");
    run_vec(1, 0, "R1");
    run_vec(0, 1, "R1");
    run_vec(-1, 0, "R4");
    run_vec(-1, -1, "R4");

    // Full circle, one degree apart (R1, R2, R4, R10)
    for (int k = 0; k < 360; k++) begin
      int xv, yv;
      xv = $rtoi(20000.0 * $cos(k * pi_r / 180.0));
      yv = $rtoi(20000.0 * $sin(k * pi_r / 180.0));
      run_vec(xv, yv, (xv < 0) ? "R4" : "R2");
    end

    // Dense small grid around the origin (R1, R4, R5)
    for (int xv = -8; xv < 8; xv++)
      for (int yv = -8; yv < 8; yv++)
        run_vec(xv, yv, (xv < 0) ? "R4" : "R1");

    // R7: start while busy is ignored
    model(12345, -6789, a0, m0);
    @(negedge clk); x_in = 16'sd12345; y_in = -16'sd6789; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    x_in = -16'sd500; y_in = 16'sd900; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 5;
    while (!done_o && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == ITER + 1, "R7", "latency with busy start", lat, ITER + 1);
    chk(longint'(angle_o) == a0, "R7", "angle with busy start", angle_o, a0);
    chk(longint'(mag_o) == m0, "R7", "magnitude with busy start", mag_o, m0);

    // R9: outputs hold after done while operands change
    repeat (4) begin
      @(negedge clk); x_in = -16'sd3000; y_in = 16'sd17;
    end
    @(negedge clk);
    chk(longint'(angle_o) == a0, "R9", "angle held", angle_o, a0);
    chk(longint'(mag_o) == m0, "R9", "magnitude held", mag_o, m0);

    // A fresh start after the hold picks up new operands
    model(-3000, 17, ea, em);
    run_vec(-3000, 17, "R4");
    chk(longint'(angle_o) == ea, "R9", "new result after start", angle_o, ea);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule